// File: doc/BRIEF.md
# Six-Pin GPIO Port with Pull and Clock-Out Control

A general-purpose I/O port of six pins that sits on a simple single-cycle register bus. Software programs three registers: an output data latch, a per-pin direction register and a pull-enable register. The pull-enable register also holds a clock-output control bit. For every pin the block drives an output value, an output enable and separate pull-up and pull-down enables. The external pin levels pass through a two-flop synchronizer before a port read can see them.

A pull device works only on a pin that is configured as an input. Its direction comes from an external per-pin polarity vector, so the port can pull up or pull down. Pin 2 is input-only. Pin 4 can be switched to carry a supplied clock. This switch works only while an input flag reports that an internal or RC clock source is in use.

Top module: `gpio_pull_port`

## Requirements
- R1: A read at address 0 returns, for each pin, the data latch when the pin's effective direction is 1 (output) and the synchronized pin level when it is 0. A change on `pin_in` becomes visible to the read after two rising clock edges. Bits 7:6 read 0.
- R2: A write at address 0 always updates the data latch, whatever the direction bits hold.
- R3: `pull_up[i]` is 1 exactly when pull-enable bit i is 1, pin i is an input and `pull_pol[i]` is 1. `pull_dn[i]` follows the same rule with `pull_pol[i]` equal to 0.
- R4: A pin whose effective direction is output has both of its pull enables at 0, with no further register write needed.
- R5: `pin_oe` equals the effective direction bits. `pin_out` equals the data latch, except pin 4 in clock mode.
- R6: Address 2 reads back pull-enable bits 5:0 in bits 5:0 and the clock-output control in bit 7. Bit 6 always reads 0.
- R7: Pin 2 is input-only. Its output enable stays 0, bit 2 of the direction register (address 1) always reads 0, and its pull follows R3 as for an input.
- R8: When address-2 bit 7 is 1 and `osc_internal` is 1, pin 4 is in clock mode: `pin_out[4]` follows `clk_src`, `pin_oe[4]` is 1 and both pulls of pin 4 are 0.
- R9: When `osc_internal` is 0, the clock-output control bit has no effect and pin 4 behaves as ordinary I/O.
- R10: After reset every register is 0, so all pins are inputs and no pull is active. Address 3 reads 0, and so do bits 7:6 of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 pull enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 6 | Raw pin levels |
| pull_pol | input | 6 | Per-pin pull polarity, 1 = up |
| osc_internal | input | 1 | Internal or RC clock source selected |
| clk_src | input | 1 | Clock to drive out on pin 4 |
| pin_out | output | 6 | Pin output values |
| pin_oe | output | 6 | Pin output enables |
| pull_up | output | 6 | Pull-up enables |
| pull_dn | output | 6 | Pull-down enables |

## Verification
Clock mode and the pull function both act on pin 4. One write to address 2 can set bit 7 and bit 4 together, so both claim pin 4 in the same cycle. The bench makes this write with `osc_internal` at 1 and then at 0. It then judges pin 4: in clock mode the output enable must be 1, the pulls must be 0 and the output must follow `clk_src`. Without clock mode the pull must follow the polarity input. A second collision comes from the sweep over every direction and pull-enable pattern, where a pin that turns into an output must lose its pull in the same cycle the direction register changes.

// File: rtl/gpio_pull_port.sv
module gpio_pull_port #(
  parameter int NPIN        = 6,
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int CLK_PIN     = 4,
  parameter int IN_ONLY_PIN = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pull_pol,
  input  logic            osc_internal,
  input  logic            clk_src,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pull_up,
  output logic [NPIN-1:0] pull_dn
);
  localparam logic [AW-1:0]   A_DATA  = AW'(0);
  localparam logic [AW-1:0]   A_DIR   = AW'(1);
  localparam logic [AW-1:0]   A_PULL  = AW'(2);
  localparam logic [NPIN-1:0] ONE     = NPIN'(1);
  localparam logic [NPIN-1:0] IN_MASK = ONE << IN_ONLY_PIN;
  localparam logic [NPIN-1:0] CK_MASK = ONE << CLK_PIN;

  logic [NPIN-1:0] latch_q, dir_q, pue_q;
  logic            ckout_q;
  logic [NPIN-1:0] sync_q [SYNC_STAGES];

  wire wr = bus_sel && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pue_q   <= '0;
      ckout_q <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        A_DATA: latch_q <= bus_wdata[NPIN-1:0];
        A_DIR:  dir_q   <= bus_wdata[NPIN-1:0];
        A_PULL: begin
          pue_q   <= bus_wdata[NPIN-1:0];
          ckout_q <= bus_wdata[DW-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  wire             ck_mode  = ckout_q && osc_internal;
  wire [NPIN-1:0]  ck_sel   = ck_mode ? CK_MASK : '0;
  wire [NPIN-1:0]  dir_eff  = dir_q & ~IN_MASK;
  wire [NPIN-1:0]  pin_sync = sync_q[SYNC_STAGES-1];
  wire [NPIN-1:0]  pull_on  = pue_q & ~dir_eff & ~ck_sel;
  wire [NPIN-1:0]  rd_port  = (latch_q & dir_eff) | (pin_sync & ~dir_eff);

  assign pin_oe  = dir_eff | ck_sel;
  assign pin_out = (latch_q & ~ck_sel) | (ck_sel & {NPIN{clk_src}});
  assign pull_up = pull_on & pull_pol;
  assign pull_dn = pull_on & ~pull_pol;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA: bus_rdata[NPIN-1:0] = rd_port;
      A_DIR:  bus_rdata[NPIN-1:0] = dir_eff;
      A_PULL: begin
        bus_rdata[NPIN-1:0] = pue_q;
        bus_rdata[DW-1]     = ckout_q;
      end
      default: ;
    endcase
  end
endmodule

module gpio_pull_port_chk #(
  parameter int NPIN        = 6,
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int CLK_PIN     = 4,
  parameter int IN_ONLY_PIN = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pull_pol,
  input logic            osc_internal,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] pull_up,
  input logic [NPIN-1:0] pull_dn
);
  localparam logic [NPIN-1:0] KEEP = ~(NPIN'(1) << CLK_PIN);

  p_pull_off_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & (pull_up | pull_dn)) == '0);

  p_pull_polarity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up & ~pull_pol) | (pull_dn & pull_pol)) == '0);

  p_input_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[IN_ONLY_PIN]);

  p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == AW'(0)) |=>
      (((pin_out ^ $past(bus_wdata[NPIN-1:0])) & KEEP) == '0));

  p_read_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == AW'(0)) |->
      (((bus_rdata[NPIN-1:0] ^ pin_out) & pin_oe & KEEP) == '0));

  p_clock_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == AW'(2) && bus_wdata[DW-1]) |=>
      (!osc_internal || pin_oe[CLK_PIN]));

  p_clock_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == AW'(1) && !bus_wdata[CLK_PIN]) |=>
      (osc_internal || !pin_oe[CLK_PIN]));

  p_pull_bit6_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(2)) |-> !bus_rdata[DW-2]);

  p_hole_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(3)) |-> (bus_rdata == '0));
endmodule

bind gpio_pull_port gpio_pull_port_chk #(
  .NPIN(NPIN), .DW(DW), .AW(AW), .CLK_PIN(CLK_PIN), .IN_ONLY_PIN(IN_ONLY_PIN)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pull_pol(pull_pol), .osc_internal(osc_internal), .pin_out(pin_out),
  .pin_oe(pin_oe), .pull_up(pull_up), .pull_dn(pull_dn)
);

// File: tb/test_gpio_pull_port.sv
`timescale 1ns/1ps
module test_gpio_pull_port;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [5:0] pin_in = 0, pull_pol = 0, pin_out, pin_oe, pull_up, pull_dn;
  logic osc_internal = 0, clk_src = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_pull_port i_gpio_pull_port (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [5:0] deff, exp6, pol;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    rd(0, r); chk("R10 data", r, 0);
    rd(1, r); chk("R10 dir", r, 0);
    rd(2, r); chk("R10 pull", r, 0);
    rd(3, r); chk("R10 hole", r, 0);
    chk("R10 oe/pulls", {pin_oe, pull_up, pull_dn}, 0);

    // R6 pull register readback
    wr(2, 8'hFF); rd(2, r); chk("R6 bit6", r, 8'hBF);
    wr(2, 8'h00);
    // R7/R10 direction readback
    wr(1, 8'hFF); rd(1, r); chk("R7 dir bit2 reads 0", r, 8'h3B);
    chk("R7 oe", pin_oe, 6'h3B);

    // R3 R4 R7 sweep over every direction and pull pattern
    for (int d = 0; d < 64; d++) begin
      wr(1, 8'(d));
      for (int p = 0; p < 64; p++) begin
        pol = 6'(d * 7 + p * 3);
        pull_pol = pol;
        wr(2, 8'(p));
        deff = 6'(d) & 6'h3B;
        exp6 = 6'(p) & ~deff;
        chk("R3/R4 pulls", {pin_oe, pull_up, pull_dn},
            {deff, exp6 & pol, exp6 & ~pol});
      end
    end
    wr(2, 0);

    // R1 R2 R5 read mux sweep
    for (int d = 0; d < 64; d++) begin
      logic [5:0] l;
      l = 6'(d) ^ 6'h2A;
      pin_in = 6'(d * 5) ^ 6'h15;
      wr(0, {2'b00, l});
      wr(1, 8'(d));
      @(negedge clk);
      deff = 6'(d) & 6'h3B;
      rd(0, r);
      chk("R1 port read", r, {2'b00, (l & deff) | (pin_in & ~deff)});
      chk("R5 out/oe", {pin_out, pin_oe}, {l, deff});
    end

    // R2 latch written while all inputs, visible after turning outputs
    wr(1, 0); pin_in = 6'h00;
    wr(0, 8'h3F);
    wr(1, 8'h3F);
    rd(0, r); chk("R2 latch write as input", r, 8'h3B);

    // R1 synchronizer latency
    wr(1, 0); pin_in = 0;
    repeat (3) @(negedge clk);
    pin_in = 6'h3F;
    @(negedge clk); rd(0, r); chk("R1 one edge", r, 8'h00);
    @(negedge clk); rd(0, r); chk("R1 two edges", r, 8'h3F);

    // R8 clock mode colliding with pull on pin 4
    wr(0, 0);
    pull_pol = 6'h3F; osc_internal = 1;
    wr(2, 8'h90);
    clk_src = 0; #0.5;
    chk("R8 oe/pull", {pin_oe[4], pull_up[4], pull_dn[4], pin_out[4]}, 4'b1000);
    clk_src = 1; #0.5;
    chk("R8 follows clk", pin_out[4], 1);
    rd(2, r); chk("R8 readback", r, 8'h90);
    // R9 flag low: control bit ignored
    osc_internal = 0; #0.5;
    chk("R9 pin4 plain", {pin_oe[4], pull_up[4], pull_dn[4], pin_out[4]}, 4'b0100);
    pull_pol = 0; #0.5;
    chk("R9 pull down", {pull_up[4], pull_dn[4]}, 2'b01);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule